// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit drives the address side of a multi-register load or store. A single start pulse hands it a 32-bit base address, a 16-bit register-select mask, a 2-bit addressing mode and a writeback flag. It then issues one transfer per clock cycle. Each transfer names a word address and the index of the register to move. The memory and the register file sit outside the block.

Selected registers are always moved in ascending register-number order. Their addresses also climb in steps of 4 bytes, so the lowest-numbered register always lands at the lowest address. The mode decides only where that run of addresses sits relative to the base. After the last transfer the unit pulses a done strobe. It also presents the updated base value, and flags it as valid when writeback was requested.

A typical use is a block copy loop. It alternates an increment-after load of eight registers with an increment-after store of eight registers. Each step feeds the returned base back in as the next base.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset, `xfer_valid`, `done`, `wb_valid` and `busy` are all low.
- R2: `mode` is encoded as 0 = increment-after, 1 = increment-before, 2 = decrement-after, 3 = decrement-before. With n set bits in `sel`, the first transfer address is base, base+4, base-4n+4 or base-4n respectively. That first transfer appears in the cycle after the clock edge that accepts `start`.
- R3: Transfers name the selected registers (bit i of `sel` selects register i) in strictly increasing index order. Consecutive transfers use addresses exactly 4 apart, and there are no gaps between transfer cycles.
- R4: The number of transfer cycles equals the number of set bits in `sel`.
- R5: `done` is high for exactly one cycle, in the cycle right after the last transfer. It never coincides with `xfer_valid`.
- R6: In the `done` cycle, `wb_valid` equals the `wb_en` captured at start. `wb_addr` holds base+4n for modes 0 and 1, and base-4n for modes 2 and 3. `wb_valid` is never high outside `done`.
- R7: While `busy` is high (during transfers and during the `done` cycle), `start` is ignored. The running sequence is unchanged, and no extra transfers or `done` pulses follow.
- R8: An all-zero `sel` produces no transfers. `done` rises in the cycle after `start`, and `wb_addr` equals the base.
- R9: Address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only when not busy) |
| base | input | 32 | Base byte address |
| sel | input | 16 | Register-select mask, bit i selects register i |
| mode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| wb_en | input | 1 | Request base writeback |
| busy | output | 1 | Sequence in progress or completing |
| xfer_valid | output | 1 | A transfer is issued this cycle |
| xfer_addr | output | 32 | Word address of the transfer |
| xfer_reg | output | 4 | Register index of the transfer |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Writeback value is valid (with done) |
| wb_addr | output | 32 | Updated base value |

## Verification
The same sparse three-register mask from one base is run in all four modes. This shows whether the starting address follows each mode and confirms that only the offset of the run changes, never the register order. A full mask at base zero in a decrement mode forces the address to wrap below zero. A single-register mask and an empty mask separate the one-transfer boundary from the case with no transfers at all. Chained eight-register increment-after steps, with writeback fed back in, and a start pulse injected mid-sequence show that the writeback value and the busy lockout are both honoured.

// File: rtl/blkxfer_seq.sv
module blkxfer_seq #(
  parameter int AW   = 32,
  parameter int NREG = 16,
  parameter int STEP = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [AW-1:0]           base,
  input  logic [NREG-1:0]         sel,
  input  logic [1:0]              mode,
  input  logic                    wb_en,
  output logic                    busy,
  output logic                    xfer_valid,
  output logic [AW-1:0]           xfer_addr,
  output logic [$clog2(NREG)-1:0] xfer_reg,
  output logic                    done,
  output logic                    wb_valid,
  output logic [AW-1:0]           wb_addr
);
  localparam int IW = $clog2(NREG);
  localparam int CW = $clog2(NREG + 1);

  function automatic logic [CW-1:0] pop(input logic [NREG-1:0] m);
    pop = '0;
    for (int i = 0; i < NREG; i++) pop = pop + CW'(m[i]);
  endfunction

  function automatic logic [IW-1:0] low_idx(input logic [NREG-1:0] m);
    low_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (m[i]) low_idx = IW'(i);
  endfunction

  logic            run_q, done_q, wbf_q;
  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   cur_q, fin_q;

  logic [AW-1:0]   span, first, last_val;
  logic [NREG-1:0] rem_nxt;
  logic            take;

  assign span     = AW'(pop(sel)) * AW'(STEP);
  assign take     = start && !busy;
  assign rem_nxt  = rem_q & (rem_q - NREG'(1));
  assign last_val = mode[1] ? base - span : base + span;

  always_comb begin
    unique case (mode)
      2'd0: first = base;
      2'd1: first = base + AW'(STEP);
      2'd2: first = base - span + AW'(STEP);
      default: first = base - span;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      wbf_q  <= 1'b0;
      rem_q  <= '0;
      cur_q  <= '0;
      fin_q  <= '0;
    end else if (take) begin
      run_q  <= |sel;
      done_q <= ~|sel;
      wbf_q  <= wb_en;
      rem_q  <= sel;
      cur_q  <= first;
      fin_q  <= last_val;
    end else if (run_q) begin
      rem_q  <= rem_nxt;
      cur_q  <= cur_q + AW'(STEP);
      if (rem_nxt == '0) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy       = run_q | done_q;
  assign xfer_valid = run_q;
  assign xfer_addr  = cur_q;
  assign xfer_reg   = low_idx(rem_q);
  assign done       = done_q;
  assign wb_valid   = done_q & wbf_q;
  assign wb_addr    = fin_q;
endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
  parameter int AW   = 32,
  parameter int NREG = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    xfer_valid,
  input logic [AW-1:0]           xfer_addr,
  input logic [$clog2(NREG)-1:0] xfer_reg,
  input logic                    done,
  input logic                    wb_valid
);
  a_r2_first_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_valid) |-> $past(start && !busy));

  a_r3_step_and_order: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && $past(xfer_valid)) |->
      (xfer_addr == $past(xfer_addr) + AW'(4)) && (xfer_reg > $past(xfer_reg)));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && xfer_valid));

  a_r6_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);

  a_r7_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid || done) |-> busy);

  a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(xfer_valid) || $past(start && !busy)));
endmodule

bind blkxfer_seq blkxfer_seq_chk #(.AW(AW), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_reg(xfer_reg),
  .done(done), .wb_valid(wb_valid)
);

// File: tb/blkxfer_seq_tb.sv
module blkxfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base = '0;
  logic [15:0] sel = '0;
  logic [1:0]  mode = '0;
  logic        wb_en = 1'b0;
  logic        busy, xfer_valid, done, wb_valid;
  logic [31:0] xfer_addr, wb_addr;
  logic [3:0]  xfer_reg;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  blkxfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .sel(sel),
    .mode(mode), .wb_en(wb_en), .busy(busy), .xfer_valid(xfer_valid),
    .xfer_addr(xfer_addr), .xfer_reg(xfer_reg), .done(done),
    .wb_valid(wb_valid), .wb_addr(wb_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_seq(input string tag, input logic [31:0] b, input logic [15:0] m,
                         input logic [1:0] md, input logic w, input bit intrude,
                         output logic [31:0] wb_out);
    int n, k, cyc, idx;
    logic [31:0] span, first, fin, ea;
    bit got_done;
    n = $countones(m);
    span = 32'(n) * 32'd4;
    case (md)
      2'd0: first = b;
      2'd1: first = b + 32'd4;
      2'd2: first = b - span + 32'd4;
      default: first = b - span;
    endcase
    fin = md[1] ? b - span : b + span;
    wb_out = fin;
    @(negedge clk);
    start = 1'b1; base = b; sel = m; mode = md; wb_en = w;
    @(negedge clk);
    start = 1'b0; base = 32'h5A5A_5A5A; sel = 16'h8001; mode = ~md; wb_en = ~w;
    k = 0; idx = 0; got_done = 0;
    for (int c = 1; c <= 40; c++) begin
      cyc = c;
      if (xfer_valid) begin
        while (idx < 16 && !m[idx]) idx++;
        ea = first + 32'(k) * 32'd4;
        chk(xfer_addr == ea, {k == 0 ? "R2 " : "R3 ", tag, " addr"}, xfer_addr, ea);
        chk(xfer_reg == 4'(idx), {"R3 ", tag, " reg"}, 32'(xfer_reg), 32'(idx));
        idx++; k++;
      end
      if (done) begin
        chk(cyc == n + 1, {"R5 ", tag, " done cycle"}, 32'(cyc), 32'(n + 1));
        chk(wb_valid == w, {"R6 ", tag, " wb_valid"}, 32'(wb_valid), 32'(w));
        chk(wb_addr == fin, {"R6 ", tag, " wb_addr"}, wb_addr, fin);
        if (m == '0) chk(wb_addr == b, {"R8 ", tag, " base kept"}, wb_addr, b);
        got_done = 1;
      end
      if (intrude && c == 1) begin
        start = 1'b1; base = 32'hDEAD_0000; sel = 16'hFFFF; mode = 2'd1; wb_en = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (got_done) break;
      @(negedge clk);
    end
    start = 1'b0;
    chk(k == n, {"R4 ", tag, " transfer count"}, 32'(k), 32'(n));
    chk(got_done, {"R5 ", tag, " done seen"}, 32'(got_done), 32'd1);
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      chk(!xfer_valid && !done && !wb_valid, {"R7 ", tag, " quiet after done"},
          {29'd0, xfer_valid, done, wb_valid}, 32'd0);
    end
  endtask

  task automatic t_reset;
    chk(!xfer_valid && !done && !wb_valid && !busy, "R1 reset outputs",
        {28'd0, xfer_valid, done, wb_valid, busy}, 32'd0);
  endtask

  task automatic t_modes;
    logic [31:0] r;
    run_seq("inc-after",  32'h0000_0010, 16'h0025, 2'd0, 1'b1, 1'b0, r);
    run_seq("inc-before", 32'h0000_0010, 16'h0025, 2'd1, 1'b1, 1'b0, r);
    run_seq("dec-after",  32'h0000_0010, 16'h0025, 2'd2, 1'b1, 1'b0, r);
    run_seq("dec-before", 32'h0000_0010, 16'h0025, 2'd3, 1'b1, 1'b0, r);
  endtask

  task automatic t_no_wb;
    logic [31:0] r;
    run_seq("R6 no writeback", 32'h0000_1000, 16'h8100, 2'd2, 1'b0, 1'b0, r);
  endtask

  task automatic t_single;
    logic [31:0] r;
    run_seq("single reg", 32'h0000_2000, 16'h8000, 2'd3, 1'b1, 1'b1, r);
  endtask

  task automatic t_empty;
    logic [31:0] r;
    run_seq("R8 empty mask", 32'h0000_3000, 16'h0000, 2'd1, 1'b1, 1'b0, r);
  endtask

  task automatic t_wrap;
    logic [31:0] r;
    run_seq("R9 wrap below zero", 32'h0000_0000, 16'hFFFF, 2'd3, 1'b1, 1'b0, r);
    run_seq("R9 wrap above top", 32'hFFFF_FFF8, 16'h0007, 2'd1, 1'b1, 1'b0, r);
  endtask

  task automatic t_intrude;
    logic [31:0] r;
    run_seq("R7 start while busy", 32'h0000_4000, 16'h0F0F, 2'd0, 1'b1, 1'b1, r);
  endtask

  task automatic t_copy_loop;
    logic [31:0] src, dst, r;
    src = 32'h0000_8000; dst = 32'h0000_9000;
    for (int it = 0; it < 2; it++) begin
      run_seq("R6 copy load", src, 16'h00FF, 2'd0, 1'b1, 1'b0, r);
      src = r;
      run_seq("R6 copy store", dst, 16'h00FF, 2'd0, 1'b1, 1'b0, r);
      dst = r;
    end
    chk(src == 32'h0000_8040, "R6 chained source base", src, 32'h0000_8040);
    chk(dst == 32'h0000_9040, "R6 chained dest base", dst, 32'h0000_9040);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_modes;
    t_no_wb;
    t_single;
    t_empty;
    t_wrap;
    t_intrude;
    t_copy_loop;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule